// File: doc/BRIEF.md
# Endpoint Packet DMA Engine

This block moves bytes between USB endpoint buffers and system memory over eight independent channels. Software sets up a channel through a small register window. It writes the memory address, then the byte count, then a control word. The control word names the endpoint and the direction, picks a transfer mode and a burst type, and starts the transfer when its enable bit is set. One transfer may be up to 0x10000 bytes long.

One shared engine serves the channels. It takes a channel whose endpoint reports ready and moves that channel's data one byte per granted memory beat. Each beat raises the channel's address register by one and lowers its count by one. When the transfer ends, software can subtract the start address from the address register to learn how many bytes moved.

A transfer ends when the count runs out, at the end of a packet in single-packet mode, or on a bus error. The channel then drops its enable bit. If interrupts are enabled for that channel, it also sets its bit in a shared status register, which drives one interrupt line.

Top module: `dma_engine`

## Requirements
- R1: Register offsets are fixed. Offset 0x200 holds the interrupt status register, with bit n for channel n. Channel n's control word is at 0x204+16n, its address at 0x208+16n and its count at 0x20C+16n. After reset every register reads 0 and `irqOut` is low.
- R2: Control word bits are fixed. Bit 0 is enable, bit 1 is direction (1 = memory to endpoint), bit 2 is multi-packet mode, bit 3 is interrupt enable, bits 7:4 are the endpoint number, bit 8 is the bus-error flag and bits 10:9 are the burst type. A write to the control word stores bits 10:0, and a read returns them.
- R3: Writing the control word with bit 0 set starts the channel. Each granted beat moves one byte, adds 1 to the address and subtracts 1 from the count.
- R4: When the count reaches 0, the channel clears bit 0 and, if bit 3 is set, sets its status bit. The final address minus the start address equals the number of bytes moved.
- R5: A channel with bit 3 clear still finishes and clears bit 0, but it sets no status bit and leaves `irqOut` low.
- R6: In single-packet mode (bit 2 = 0), the channel finishes after one packet of PKT_BYTES bytes (default 8) even if the count is not yet 0. The count register then shows the bytes left.
- R7: In multi-packet mode, the channel keeps moving packets until the count is 0. Between packets it waits until its endpoint's bit in `epReady` is high.
- R8: With direction 1, the engine reads memory (`memWrite` = 0) and passes `memRdata` to `epTxData`. With direction 0, it writes memory (`memWrite` = 1) with `epRxData`. `epNum` and `epTx` show the active channel's endpoint and direction.
- R9: While a request is active, `memBurst` carries the active channel's burst type: 0 = unspecified, 1 = 4-beat, 2 = 8-beat, 3 = 16-beat.
- R10: A granted beat that also has `memErr` set ends the transfer. The channel sets bit 8, clears bit 0, sets its status bit if bit 3 is set, and does not advance its address or count.
- R11: Writing 0 to a channel's control word drops its memory request by the next cycle. The channel then stays idle, with no further beats and no status bit.
- R12: A read of offset 0x200 returns the status bits and clears every bit that was set at the time of the read. `irqOut` is the OR of the status bits.
- R13: When several enabled channels have ready endpoints, the lowest-numbered one is served. A packet in progress is never handed to another channel.
- R14: A channel started with a count of 0 finishes at once and moves no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (needed for clear-on-read) |
| regAddr | input | 10 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| irqOut | output | 1 | Interrupt line, the OR of the status bits |
| memReq | output | 1 | Memory beat request |
| memWrite | output | 1 | 1 = write to memory, 0 = read from memory |
| memAddr | output | 32 | Beat address |
| memBurst | output | 2 | Burst type of the active channel |
| memWdata | output | 8 | Write data byte |
| memRdata | input | 8 | Read data byte |
| memGrant | input | 1 | Beat accepted this cycle |
| memErr | input | 1 | Bus error on the granted beat |
| epReady | input | 16 | Per-endpoint ready flags |
| epNum | output | 4 | Endpoint of the active channel |
| epTx | output | 1 | Direction of the active channel |
| epStrobe | output | 1 | A byte moves to or from the endpoint this cycle |
| epTxData | output | 8 | Byte toward the endpoint |
| epRxData | input | 8 | Byte from the endpoint |

## Verification
The bench targets packet boundaries.

- It lowers an endpoint's ready flag exactly at a packet boundary in multi-packet mode. A design that ignored ready between packets would keep moving bytes.
- In single-packet mode, a design that ran on to the full count would leave a count of 0 where the bench expects the remaining bytes.

It also forces a bus error on the fourth beat. A design that still advanced the address, or that did not set the error flag, would give a wrong byte count and a flag that looks like a normal completion.

Finally, it checks that an abort while the memory bus is stalled actually drops the request, that a zero-count start finishes without a beat, and that two channels released in the same cycle are served lowest first.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int CH_IDX_W = 4;
  localparam int CTRL_W   = 11;
  localparam int EP_W     = 4;

  // strobes from control to the register datapath
  typedef struct packed {
    logic                beat;
    logic                busErr;
    logic                finish;
    logic [CH_IDX_W-1:0] chan;
  } dmaStrobe_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_eng_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h200
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic                        regRdEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [31:0]                 regWrData,
  output logic [31:0]                 regRdData,
  input  dmaStrobe_t                  stb,
  output logic [NCH-1:0]              enVec,
  output logic [NCH-1:0]              txVec,
  output logic [NCH-1:0]              mode1Vec,
  output logic [NCH-1:0][EP_W-1:0]    epVec,
  output logic [NCH-1:0][1:0]         burstVec,
  output logic [NCH-1:0][31:0]        addrVec,
  output logic [NCH-1:0]              cntZeroVec,
  output logic [NCH-1:0]              cntOneVec,
  output logic                        irqOut
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int WIN  = 16 * NCH;

  logic [NCH-1:0][CTRL_W-1:0] ctrlReg;
  logic [NCH-1:0][31:0]       cntReg;
  logic [NCH-1:0]             irqStat, setMask;
  logic                       winHit, rdIntr;
  logic [CH_W-1:0]            chSel;
  logic [1:0]                 regSel;

  assign winHit = (int'(regAddr) >= BASE) && (int'(regAddr) < BASE + WIN) && (regAddr[1:0] == 2'b00);
  assign chSel  = regAddr[4 +: CH_W];
  assign regSel = regAddr[3:2];
  assign rdIntr = regRdEn && winHit && regSel == 2'd0 && chSel == '0;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      setMask[i] = (stb.busErr || stb.finish) && stb.chan == CH_IDX_W'(i) && ctrlReg[i][3];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      addrVec <= '0;
      cntReg  <= '0;
      irqStat <= '0;
    end else begin
      irqStat <= (rdIntr ? '0 : irqStat) | setMask;
      for (int i = 0; i < NCH; i++) begin
        if (stb.chan == CH_IDX_W'(i)) begin
          if (stb.beat) begin
            addrVec[i] <= addrVec[i] + 32'd1;
            cntReg[i]  <= cntReg[i] - 32'd1;
          end
          if (stb.busErr) begin
            ctrlReg[i][8] <= 1'b1;
            ctrlReg[i][0] <= 1'b0;
          end
          if (stb.finish) ctrlReg[i][0] <= 1'b0;
        end
        // software writes take priority over engine updates
        if (regWrEn && winHit && chSel == CH_W'(i)) begin
          case (regSel)
            2'd1: ctrlReg[i] <= regWrData[CTRL_W-1:0];
            2'd2: addrVec[i] <= regWrData;
            2'd3: cntReg[i]  <= regWrData;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (winHit) begin
      case (regSel)
        2'd0: if (chSel == '0) regRdData[NCH-1:0] = irqStat;
        2'd1: regRdData[CTRL_W-1:0] = ctrlReg[chSel];
        2'd2: regRdData = addrVec[chSel];
        default: regRdData = cntReg[chSel];
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_fields
      assign enVec[g]      = ctrlReg[g][0];
      assign txVec[g]      = ctrlReg[g][1];
      assign mode1Vec[g]   = ctrlReg[g][2];
      assign epVec[g]      = ctrlReg[g][7:4];
      assign burstVec[g]   = ctrlReg[g][10:9];
      assign cntZeroVec[g] = cntReg[g] == 32'd0;
      assign cntOneVec[g]  = cntReg[g] == 32'd1;
    end
  endgenerate

  assign irqOut = |irqStat;

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.beat |-> cntReg[stb.chan[CH_W-1:0]] != 32'd0);

  // R12
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIntr && setMask == '0) |=> !irqOut);

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(stb.finish || stb.busErr));
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
  import dma_eng_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int PKT_BYTES = 8,
  parameter int EP_N      = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NCH-1:0]           enVec,
  input  logic [NCH-1:0]           mode1Vec,
  input  logic [NCH-1:0][EP_W-1:0] epVec,
  input  logic [NCH-1:0]           cntZeroVec,
  input  logic [NCH-1:0]           cntOneVec,
  input  logic [EP_N-1:0]          epReady,
  input  logic                     memGrant,
  input  logic                     memErr,
  output logic                     memReq,
  output logic [CH_IDX_W-1:0]      curChan,
  output dmaStrobe_t               stb
);
  localparam int PKT_W = $clog2(PKT_BYTES + 1);

  typedef enum logic {S_IDLE, S_XFER} ctlState_t;
  ctlState_t      state;
  logic [PKT_W-1:0] pktLeft;
  logic           pickHit;
  logic [CH_IDX_W-1:0] pickIdx;
  logic           curEn;

  // descending scan so the lowest ready channel wins
  always_comb begin
    pickHit = 1'b0;
    pickIdx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (enVec[i] && epReady[epVec[i]]) begin
        pickHit = 1'b1;
        pickIdx = CH_IDX_W'(i);
      end
    end
  end

  assign curEn  = enVec[curChan];
  assign memReq = (state == S_XFER) && curEn && !cntZeroVec[curChan];

  always_comb begin
    stb      = '0;
    stb.chan = curChan;
    if (state == S_XFER && curEn) begin
      if (cntZeroVec[curChan]) stb.finish = 1'b1;
      else if (memGrant) begin
        if (memErr) stb.busErr = 1'b1;
        else begin
          stb.beat   = 1'b1;
          stb.finish = cntOneVec[curChan] || (pktLeft == PKT_W'(1) && !mode1Vec[curChan]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curChan <= '0;
      pktLeft <= '0;
    end else begin
      case (state)
        S_IDLE: if (pickHit) begin
          state   <= S_XFER;
          curChan <= pickIdx;
          pktLeft <= PKT_W'(PKT_BYTES);
        end
        default: begin
          if (!curEn || stb.finish || stb.busErr) state <= S_IDLE;
          else if (stb.beat) begin
            if (pktLeft == PKT_W'(1)) state <= S_IDLE;
            else pktLeft <= pktLeft - PKT_W'(1);
          end
        end
      endcase
    end
  end

  // R10
  err_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGrant && memErr) |=> !memReq);

  // R6
  pkt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_XFER) |-> (pktLeft != '0 && int'(pktLeft) <= PKT_BYTES));

  // R13
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> curChan == $past(curChan));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_eng_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int PKT_BYTES = 8,
  parameter int EP_N      = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regRdEn,
  input  logic [9:0]   regAddr,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  output logic         irqOut,
  output logic         memReq,
  output logic         memWrite,
  output logic [31:0]  memAddr,
  output logic [1:0]   memBurst,
  output logic [7:0]   memWdata,
  input  logic [7:0]   memRdata,
  input  logic         memGrant,
  input  logic         memErr,
  input  logic [15:0]  epReady,
  output logic [3:0]   epNum,
  output logic         epTx,
  output logic         epStrobe,
  output logic [7:0]   epTxData,
  input  logic [7:0]   epRxData
);
  dmaStrobe_t                stb;
  logic [NCH-1:0]            enVec, txVec, mode1Vec, cntZeroVec, cntOneVec;
  logic [NCH-1:0][EP_W-1:0]  epVec;
  logic [NCH-1:0][1:0]       burstVec;
  logic [NCH-1:0][31:0]      addrVec;
  logic [CH_IDX_W-1:0]       curChan;

  dma_regs #(.NCH(NCH)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .stb(stb), .enVec(enVec), .txVec(txVec), .mode1Vec(mode1Vec),
    .epVec(epVec), .burstVec(burstVec), .addrVec(addrVec),
    .cntZeroVec(cntZeroVec), .cntOneVec(cntOneVec), .irqOut(irqOut)
  );

  dma_ctl #(.NCH(NCH), .PKT_BYTES(PKT_BYTES), .EP_N(EP_N)) uCtl (
    .clk(clk), .rstN(rstN), .enVec(enVec), .mode1Vec(mode1Vec),
    .epVec(epVec), .cntZeroVec(cntZeroVec), .cntOneVec(cntOneVec),
    .epReady(epReady), .memGrant(memGrant), .memErr(memErr),
    .memReq(memReq), .curChan(curChan), .stb(stb)
  );

  assign memAddr  = addrVec[curChan];
  assign memWrite = !txVec[curChan];
  assign memBurst = burstVec[curChan];
  assign memWdata = epRxData;
  assign epNum    = epVec[curChan];
  assign epTx     = txVec[curChan];
  assign epStrobe = memReq && memGrant && !memErr;
  assign epTxData = memRdata;
endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [9:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic irqOut, memReq, memWrite, memGrant, memErr, epTx, epStrobe;
  logic [31:0] memAddr;
  logic [1:0] memBurst;
  logic [7:0] memWdata, memRdata, epTxData, epRxData;
  logic [15:0] epReady = 16'hFFFF;
  logic [3:0] epNum;
  logic grantEn = 1, errEn = 0;
  logic [31:0] errAddr = '0;

  int checks = 0, errors = 0;
  int nStrobe = 0, dataBad = 0;
  logic lastWrite;
  logic [1:0] lastBurst;
  logic [3:0] lastEp;

  always #10 clk = ~clk;

  assign memGrant = memReq && grantEn;
  assign memErr   = memReq && errEn && memAddr == errAddr;
  assign memRdata = memAddr[7:0] ^ 8'h5A;
  assign epRxData = 8'hC3;

  dma_engine dut (.*);

  always @(posedge clk) begin
    if (epStrobe) begin
      lastWrite = memWrite;
      lastBurst = memBurst;
      lastEp    = epNum;
      if (epTx && epTxData != (memAddr[7:0] ^ 8'h5A)) dataBad++;
      if (!epTx && memWdata != 8'hC3) dataBad++;
      nStrobe++;
    end
  end

  function automatic logic [9:0] aCtl(int n); return 10'(32'h204 + 16 * n); endfunction
  function automatic logic [9:0] aAdr(int n); return 10'(32'h208 + 16 * n); endfunction
  function automatic logic [9:0] aCnt(int n); return 10'(32'h20C + 16 * n); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic setup(input int n, input logic [31:0] ad, input logic [31:0] cn, input logic [31:0] ct);
    wr(aAdr(n), ad); wr(aCnt(n), cn); wr(aCtl(n), ct);
  endtask

  task automatic waitIrq(input string tag);
    int k = 0;
    while (!irqOut && k < 2000) begin @(negedge clk); k++; end
    chk(tag, 32'(irqOut), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(10'h200, d); chk("R1 intr reset", d, 0);
    rd(aCtl(3), d); chk("R1 ctrl reset", d, 0);
    rd(aAdr(7), d); chk("R1 addr reset", d, 0);
    rd(aCnt(0), d); chk("R1 count reset", d, 0);
    chk("R1 irq reset", 32'(irqOut), 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(aCtl(6), 32'h6FE); rd(aCtl(6), d); chk("R2 ctrl fields readback", d, 32'h6FE);
    wr(aCtl(6), 0);
  endtask

  task automatic t_rxMulti();
    logic [31:0] d; int b = nStrobe;
    setup(0, 32'h1000, 20, 32'h62D);
    waitIrq("R4 rx irq");
    chk("R3 rx beats", 32'(nStrobe - b), 20);
    rd(aAdr(0), d); chk("R4 addr minus start", d - 32'h1000, 20);
    rd(aCnt(0), d); chk("R3 count zero", d, 0);
    rd(aCtl(0), d); chk("R4 enable cleared", d, 32'h62C);
    chk("R8 rx writes memory", 32'(lastWrite), 1);
    chk("R9 burst 16", 32'(lastBurst), 3);
    chk("R8 data path", 32'(dataBad), 0);
    rd(10'h200, d); chk("R12 intr read", d, 32'h01);
    chk("R12 irq low after read", 32'(irqOut), 0);
    rd(10'h200, d); chk("R12 cleared", d, 0);
  endtask

  task automatic t_txSingle();
    logic [31:0] d; int b = nStrobe;
    setup(1, 32'h2000, 20, 32'h25B);
    waitIrq("R6 tx irq");
    chk("R6 one packet", 32'(nStrobe - b), 8);
    rd(aCnt(1), d); chk("R6 remaining count", d, 12);
    rd(aAdr(1), d); chk("R6 addr", d, 32'h2008);
    chk("R8 tx reads memory", 32'(lastWrite), 0);
    chk("R9 burst 4", 32'(lastBurst), 1);
    chk("R8 tx data", 32'(dataBad), 0);
    rd(10'h200, d); chk("R12 intr bit1", d, 32'h02);
  endtask

  task automatic t_multiWait();
    logic [31:0] d; int b = nStrobe;
    setup(2, 32'h4000, 12, 32'h3D);
    wait (nStrobe == b + 8);
    @(negedge clk); epReady[3] = 0;
    repeat (20) @(negedge clk);
    chk("R7 paused between packets", 32'(nStrobe - b), 8);
    rd(aCnt(2), d); chk("R7 count while paused", d, 4);
    chk("R7 no request while paused", 32'(memReq), 0);
    epReady[3] = 1;
    waitIrq("R7 irq");
    chk("R7 total beats", 32'(nStrobe - b), 12);
    rd(10'h200, d); chk("R7 intr bit2", d, 32'h04);
  endtask

  task automatic t_noIe();
    logic [31:0] d;
    setup(3, 32'h500, 3, 32'h85);
    repeat (30) @(negedge clk);
    rd(aCtl(3), d); chk("R5 enable cleared", d, 32'h84);
    rd(aCnt(3), d); chk("R5 count done", d, 0);
    chk("R5 irq low", 32'(irqOut), 0);
    rd(10'h200, d); chk("R5 no status", d, 0);
  endtask

  task automatic t_busErr();
    logic [31:0] d; int b = nStrobe;
    errAddr = 32'h3003; errEn = 1;
    setup(4, 32'h3000, 10, 32'h4D);
    waitIrq("R10 irq");
    errEn = 0;
    chk("R10 beats before error", 32'(nStrobe - b), 3);
    rd(aCtl(4), d); chk("R10 error flag", d, 32'h14C);
    rd(aAdr(4), d); chk("R10 addr held", d, 32'h3003);
    rd(aCnt(4), d); chk("R10 count held", d, 7);
    rd(10'h200, d); chk("R10 intr bit4", d, 32'h10);
  endtask

  task automatic t_abort();
    logic [31:0] d; int b = nStrobe;
    grantEn = 0;
    setup(5, 32'h5000, 6, 32'h19);
    repeat (3) @(negedge clk);
    chk("R11 request pending", 32'(memReq), 1);
    wr(aCtl(5), 0);
    chk("R11 request dropped", 32'(memReq), 0);
    wr(aAdr(5), 0); wr(aCnt(5), 0);
    grantEn = 1;
    repeat (10) @(negedge clk);
    chk("R11 no beats", 32'(nStrobe - b), 0);
    chk("R11 irq low", 32'(irqOut), 0);
    rd(aAdr(5), d); chk("R11 addr zero", d, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d; int b = nStrobe;
    epReady[6] = 0; epReady[7] = 0;
    setup(7, 32'h7000, 4, 32'h79);
    setup(6, 32'h6000, 4, 32'h69);
    @(negedge clk); epReady[6] = 1; epReady[7] = 1;
    wait (nStrobe == b + 1);
    chk("R13 lowest channel first", 32'(lastEp), 6);
    repeat (40) @(negedge clk);
    chk("R13 all beats", 32'(nStrobe - b), 8);
    rd(10'h200, d); chk("R13 both done", d, 32'hC0);
  endtask

  task automatic t_zero();
    logic [31:0] d; int b = nStrobe;
    setup(0, 32'h100, 0, 32'h09);
    waitIrq("R14 irq");
    chk("R14 no beats", 32'(nStrobe - b), 0);
    rd(aAdr(0), d); chk("R14 addr unchanged", d, 32'h100);
    rd(10'h200, d); chk("R14 intr bit0", d, 32'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_layout();
    t_rxMulti();
    t_txSingle();
    t_multiWait();
    t_noIe();
    t_busErr();
    t_abort();
    t_priority();
    t_zero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule